// File: doc/BRIEF.md
# Multimode General Purpose Timer

A peripheral timer whose single counter runs at the peripheral clock and is shared by three operating modes, chosen through a control register. In waveform mode the counter sweeps from zero to the programmed period minus one, and the output pin is high for the first `width` clocks of each sweep. In capture mode the counter times an external input, and the high time and the repetition time of that input are written back into the width and period registers. In watchdog mode the counter counts rising edges of the external input and signals once a programmed number of them has arrived.

Each instance is independent of any other timer. Software reaches the block through a simple register port with a single-cycle write strobe and a combinational read. The external input always passes through a multi-flop synchroniser before its edges are detected. Disabling the block clears the counter but leaves the sticky status flags in place.

Top module: `mm_gp_timer`

## Requirements
- R1: After reset, `pulse_o` and `irq_o` are 0 and every register (control 0, period 1, width 2, status 3, count 4 on `reg_addr`) reads 0.
- R2: In waveform mode (control bits [2:1] = 0, bit 0 = enable) with a valid setting, `irq_o` is a one-clock pulse that repeats every `period` clocks.
- R3: In waveform mode, `pulse_o` is high for exactly `width` of the `period` clocks in every cycle of the counter.
- R4: In waveform mode a period of zero, or a width not smaller than the period, sets status bit 0 and holds `pulse_o` low.
- R5: In capture mode (control bits [2:1] = 1) a rising edge of `ext_i` writes the clocks since the previous rising edge into the period register, and a falling edge writes the clocks since the last rising edge into the width register.
- R6: In capture mode `irq_o` pulses on each rising edge of `ext_i` except the first after enabling.
- R7: In watchdog mode (control bits [2:1] = 2) every rising edge of `ext_i` advances the counter; when `period` edges have arrived `irq_o` pulses and the count restarts from zero.
- R8: Writing enable bit 0 low clears the counter (count register reads 0) and leaves the status flags unchanged.
- R9: Status bit 1 is set on every `irq_o` pulse; writing a 1 to a status bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| ext_i | input | 1 | External input, asynchronous |
| pulse_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Waveform mode is run with several period and width pairs, including a width of one and a width of period minus one, so that off-by-one errors in the wrap point and in the high-time compare give different interrupt spacings or high counts. Capture mode is fed an input whose first gap differs from later gaps, which separates a capture taken from the latest edge pair from a stale one, and the interrupt count before and after the second edge shows whether the first edge is wrongly reported. Watchdog mode receives an edge count that is not a multiple of the period, so the leftover count tells a correct wrap from one that is early or late. Invalid settings and a disable after an error show that the error flag is sticky and that disabling clears only the counter.

// File: rtl/mm_gp_timer_pkg.sv
package mm_gp_timer_pkg;
   typedef enum logic [1:0] {
      MODE_WAVE = 2'd0,
      MODE_CAPT = 2'd1,
      MODE_WDOG = 2'd2,
      MODE_IDLE = 2'd3
   } tmr_mode_e;

   localparam logic [2:0] RA_CTRL   = 3'd0;
   localparam logic [2:0] RA_PERIOD = 3'd1;
   localparam logic [2:0] RA_WIDTH  = 3'd2;
   localparam logic [2:0] RA_STAT   = 3'd3;
   localparam logic [2:0] RA_COUNT  = 3'd4;

   localparam int STAT_ERR = 0;
   localparam int STAT_IRQ = 1;
endpackage

// File: rtl/mm_gp_timer_sync.sv
module mm_gp_timer_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mm_gp_timer_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= din;
   end

   generate
      for (genvar i = 1; i <= LAST; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign rise = chain[LAST-1] & ~chain[LAST];
   assign fall = ~chain[LAST-1] & chain[LAST];

   a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/mm_gp_timer_core.sv
module mm_gp_timer_core
   import mm_gp_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  tmr_mode_e        mode,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] width,
   input  logic             rise,
   input  logic             fall,
   output logic [CNT_W-1:0] cnt,
   output logic             pulse_o,
   output logic             irq_o,
   output logic             err_set,
   output logic             cap_per_vld,
   output logic [CNT_W-1:0] cap_per,
   output logic             cap_wid_vld,
   output logic [CNT_W-1:0] cap_wid
);
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic             seen_rise;
   logic             wave_bad;
   logic             wdog_bad;
   logic [CNT_W-1:0] last_val;
   logic             at_last;
   logic [CNT_W-1:0] cnt_inc;

   assign wave_bad = (period == '0) || (width >= period);
   assign wdog_bad = (period == '0);
   assign last_val = period - ONE;
   assign at_last  = (cnt >= last_val);
   assign cnt_inc  = (cnt == CMAX) ? cnt : cnt + ONE;

   assign err_set = en && (((mode == MODE_WAVE) && wave_bad) ||
                           ((mode == MODE_WDOG) && wdog_bad));
   assign pulse_o = en && (mode == MODE_WAVE) && !wave_bad && (cnt < width);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         seen_rise   <= 1'b0;
         irq_o       <= 1'b0;
         cap_per_vld <= 1'b0;
         cap_per     <= '0;
         cap_wid_vld <= 1'b0;
         cap_wid     <= '0;
      end else if (!en) begin
         cnt         <= '0;
         seen_rise   <= 1'b0;
         irq_o       <= 1'b0;
         cap_per_vld <= 1'b0;
         cap_wid_vld <= 1'b0;
      end else begin
         irq_o       <= 1'b0;
         cap_per_vld <= 1'b0;
         cap_wid_vld <= 1'b0;
         unique case (mode)
            MODE_WAVE: begin
               cnt   <= at_last ? '0 : cnt + ONE;
               irq_o <= at_last && !wave_bad;
            end
            MODE_CAPT: begin
               if (rise) begin
                  cnt         <= '0;
                  seen_rise   <= 1'b1;
                  irq_o       <= seen_rise;
                  cap_per_vld <= seen_rise;
                  cap_per     <= cnt_inc;
               end else begin
                  cnt <= cnt_inc;
               end
               if (fall && seen_rise) begin
                  cap_wid_vld <= 1'b1;
                  cap_wid     <= cnt_inc;
               end
            end
            MODE_WDOG: begin
               if (rise && !wdog_bad) begin
                  if (at_last) begin
                     cnt   <= '0;
                     irq_o <= 1'b1;
                  end else begin
                     cnt <= cnt + ONE;
                  end
               end
            end
            default: cnt <= cnt;
         endcase
      end
   end

   a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   a_r6_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq_o);
   a_r4_bad_wave_low: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set && (mode == MODE_WAVE)) |-> !pulse_o);
endmodule

// File: rtl/mm_gp_timer_regs.sv
module mm_gp_timer_regs
   import mm_gp_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cap_per_vld,
   input  logic [CNT_W-1:0] cap_per,
   input  logic             cap_wid_vld,
   input  logic [CNT_W-1:0] cap_wid,
   input  logic             err_set,
   input  logic             irq_set,
   output logic             en,
   output tmr_mode_e        mode,
   output logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] width
);
   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("mm_gp_timer_regs: CNT_W must be at least 4");
      end
   endgenerate

   logic [1:0] status;
   logic       wr_ctrl, wr_per, wr_wid, wr_stat;

   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_per  = reg_wr && (reg_addr == RA_PERIOD);
   assign wr_wid  = reg_wr && (reg_addr == RA_WIDTH);
   assign wr_stat = reg_wr && (reg_addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         mode   <= MODE_WAVE;
         period <= '0;
         width  <= '0;
         status <= '0;
      end else begin
         if (wr_ctrl) begin
            en   <= reg_wdata[0];
            mode <= tmr_mode_e'(reg_wdata[2:1]);
         end
         if (cap_per_vld)  period <= cap_per;
         else if (wr_per)  period <= reg_wdata;
         if (cap_wid_vld)  width <= cap_wid;
         else if (wr_wid)  width <= reg_wdata;
         status[STAT_ERR] <= err_set ||
                             (status[STAT_ERR] && !(wr_stat && reg_wdata[STAT_ERR]));
         status[STAT_IRQ] <= irq_set ||
                             (status[STAT_IRQ] && !(wr_stat && reg_wdata[STAT_IRQ]));
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:   reg_rdata = {{(CNT_W-3){1'b0}}, mode, en};
         RA_PERIOD: reg_rdata = period;
         RA_WIDTH:  reg_rdata = width;
         RA_STAT:   reg_rdata = {{(CNT_W-2){1'b0}}, status};
         RA_COUNT:  reg_rdata = cnt;
         default:   reg_rdata = '0;
      endcase
   end

   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> status[STAT_IRQ]);
   a_r8_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (status[STAT_ERR] && !wr_stat) |=> status[STAT_ERR]);
endmodule

// File: rtl/mm_gp_timer.sv
module mm_gp_timer
   import mm_gp_timer_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             ext_i,
   output logic             pulse_o,
   output logic             irq_o
);
   logic             en;
   tmr_mode_e        mode;
   logic [CNT_W-1:0] period, width, cnt, cap_per, cap_wid;
   logic             rise, fall, err_set, cap_per_vld, cap_wid_vld;

   mm_gp_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_i), .rise(rise), .fall(fall));

   mm_gp_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .period(period),
      .width(width), .rise(rise), .fall(fall), .cnt(cnt), .pulse_o(pulse_o),
      .irq_o(irq_o), .err_set(err_set), .cap_per_vld(cap_per_vld),
      .cap_per(cap_per), .cap_wid_vld(cap_wid_vld), .cap_wid(cap_wid));

   mm_gp_timer_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt(cnt),
      .cap_per_vld(cap_per_vld), .cap_per(cap_per),
      .cap_wid_vld(cap_wid_vld), .cap_wid(cap_wid), .err_set(err_set),
      .irq_set(irq_o), .en(en), .mode(mode), .period(period), .width(width));

   a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pulse_o);
endmodule

// File: tb/mm_gp_timer_tb_top.sv
`timescale 1ns/1ps
module mm_gp_timer_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = 3'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         ext_i = 1'b0;
   logic         pulse_o, irq_o;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mm_gp_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_i(ext_i),
      .pulse_o(pulse_o), .irq_o(irq_o));

   always @(negedge clk) if (irq_o) irq_seen++;

   // {period, width} pairs for waveform mode
   localparam logic [15:0] VEC [4] = '{
      {8'd5, 8'd2}, {8'd8, 8'd1}, {8'd3, 8'd2}, {8'd10, 8'd7}};

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulses(input int h, input int l, input int n);
      for (int k = 0; k < n; k++) begin
         ext_i = 1'b1;
         repeat (h) @(negedge clk);
         ext_i = 1'b0;
         repeat (l) @(negedge clk);
      end
   endtask

   // measure distance between irq pulses, high samples and irq width
   task automatic measure(output int per, output int hi, output int irq_w);
      int guard = 0;
      per = 0; hi = 0; irq_w = 0;
      @(negedge clk);
      while (!irq_o && guard < 200) begin @(negedge clk); guard++; end
      do begin
         if (pulse_o) hi++;
         if (irq_o) irq_w++;
         per++;
         @(negedge clk);
      end while (!irq_o && per < 200);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d;
      int per, hi, iw;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pulse", pulse_o, 0);
      check("R1 irq", irq_o, 0);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 reg", d, 0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 waveform vectors
      foreach (VEC[i]) begin
         wr(3'd0, 0);
         wr(3'd1, W'(VEC[i][15:8]));
         wr(3'd2, W'(VEC[i][7:0]));
         wr(3'd0, 1);
         measure(per, hi, iw);
         check("R2 period", per, VEC[i][15:8]);
         check("R2 irq width", iw, 1);
         check("R3 high time", hi, VEC[i][7:0]);
      end
      rd(3'd3, d);
      check("R9 irq flag", d[1], 1);
      wr(3'd3, 2);
      rd(3'd3, d);
      check("R9 w1c", d, 0);

      // R4 invalid settings
      wr(3'd0, 0);
      wr(3'd1, 4); wr(3'd2, 4);
      wr(3'd0, 1);
      hi = 0;
      repeat (12) begin @(negedge clk); if (pulse_o) hi++; end
      check("R4 out low w>=p", hi, 0);
      rd(3'd3, d);
      check("R4 err flag", d[0], 1);
      wr(3'd3, 3);
      wr(3'd1, 0); wr(3'd2, 0);
      repeat (4) @(negedge clk);
      rd(3'd3, d);
      check("R4 err period 0", d[0], 1);

      // R8 disable keeps status, clears count
      wr(3'd1, 9); wr(3'd2, 3);
      repeat (6) @(negedge clk);
      wr(3'd0, 0);
      rd(3'd4, d);
      check("R8 count cleared", d, 0);
      rd(3'd3, d);
      check("R8 err kept", d[0], 1);
      wr(3'd3, 3);
      rd(3'd3, d);
      check("R9 clear all", d, 0);

      // R5 R6 capture
      wr(3'd0, 3);
      irq_seen = 0;
      repeat (3) @(negedge clk);
      pulses(3, 4, 1);
      repeat (5) @(negedge clk);
      check("R6 no irq on first rise", irq_seen, 0);
      pulses(3, 4, 2);
      repeat (6) @(negedge clk);
      check("R6 irq per later rise", irq_seen, 2);
      rd(3'd1, d);
      check("R5 period capture", d, 7);
      rd(3'd2, d);
      check("R5 width capture", d, 3);
      wr(3'd0, 0);

      // R7 watchdog
      wr(3'd1, 4);
      wr(3'd0, 5);
      irq_seen = 0;
      pulses(2, 2, 9);
      repeat (6) @(negedge clk);
      check("R7 wd irqs", irq_seen, 2);
      rd(3'd4, d);
      check("R7 wd leftover", d, 1);
      wr(3'd0, 0);
      rd(3'd4, d);
      check("R8 wd count cleared", d, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule